// File: doc/BRIEF.md
# Conversion Rate Scheduler with Standby

This block decides when a periodic measurement engine begins each conversion. A base tick enable arrives once per fastest conversion period (it stands for 125 ms). A 3-bit rate code in the low bits of an 8-bit rate register stretches that period by a power of two. Code 7 gives one conversion per tick. Code 0 gives one conversion every 128 ticks. Each code below 7 doubles the period of the code above it. When the block launches a conversion it raises a one-cycle start pulse. It then holds a busy flag until the engine reports completion.

A standby bit stops periodic launching. A write strobe to the one-shot location still runs exactly one conversion while in standby, and the block then stays in standby. Only the strobe carries meaning, so no data enters the block. All pins are plain control and status levels or pulses. There is no streaming interface, so there is no valid/ready handshake and no back-pressure. The engine is not allowed to stall a start pulse: a launch that falls due while a conversion is still running is dropped.

Top module: `conv_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, start_o and busy_o are low.
- R2: In run mode with rate_i[7:3] zero and code n = rate_i[2:0], start_o rises once every 2^(7-n) base ticks. It is high for exactly one clock, in the cycle that follows the clock edge sampling the tick that completes the period.
- R3: A rate value with any of bits 7..3 set is treated as code 0, which gives a period of 128 ticks.
- R4: busy_o rises in the same cycle as start_o. It falls at the first clock edge that samples conv_done_i high.
- R5: If a period completes while busy_o is high, no start is issued for it, and the next period is counted from that point.
- R6: When the effective rate code changes, the tick count is cleared. The next start then comes one full new period of ticks later.
- R7: While standby_i is high, no periodic start occurs and the tick count is held cleared. After a return to run, the first start comes one full period of ticks later.
- R8: In standby with busy_o low, a oneshot_wr_i pulse produces exactly one start_o in the following cycle. The block then remains in standby.
- R9: A oneshot_wr_i pulse has no effect while busy_o is high or while in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base tick enable, one pulse per fastest period |
| rate_i | input | 8 | Rate register; low 3 bits hold the code, upper bits must be zero |
| standby_i | input | 1 | 1 = standby, 0 = run |
| oneshot_wr_i | input | 1 | Write strobe to the one-shot location |
| conv_done_i | input | 1 | Conversion finished |
| start_o | output | 1 | One-cycle conversion start |
| busy_o | output | 1 | Conversion in progress |

## Verification
start_o is due one cycle after the edge that samples either the completing tick or an accepted one-shot strobe. busy_o drops one cycle after the edge that samples conv_done_i. A rate change or a return from standby takes effect at the first edge after the new value is applied. The bench changes inputs one time unit after a rising edge and reads outputs one time unit after the next rising edge. Each expected value therefore lines up with a single register stage. Every code, including two reserved values, is swept over two full periods, and the tick position of each start is compared with the arithmetic period.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  localparam int unsigned RATE_BITS = 8;
  localparam int unsigned CODE_BITS = 3;
  localparam int unsigned CNT_BITS  = (1 << CODE_BITS) - 1;

  typedef enum logic [1:0] {
    LNCH_IDLE = 2'b00,
    LNCH_BUSY = 2'b01
  } lnch_state_e;
endpackage

// File: rtl/conv_rate_decode.sv
module conv_rate_decode #(
  parameter int unsigned RATE_W = 8,
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = (1 << CODE_W) - 1
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  term_o
);
  logic reserved;

  generate
    if (RATE_W > CODE_W) begin : g_upper
      assign reserved = |rate_i[RATE_W-1:CODE_W];
    end else begin : g_none
      assign reserved = 1'b0;
    end
  endgenerate

  // reserved values fall back to the slowest code
  assign code_o = reserved ? '0 : rate_i[CODE_W-1:0];
  // terminal count = period - 1 = 2^(max - code) - 1
  assign term_o = {CNT_W{1'b1}} >> code_o;
endmodule

// File: rtl/conv_period_ctr.sv
module conv_period_ctr #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  term_i,
  output logic              expire_o
);
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              restart;
  logic              at_term;

  assign restart  = (code_i != code_q) || !run_i;
  assign at_term  = (cnt_q == term_i);
  assign expire_o = tick_i && at_term && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      code_q <= code_i;
      if (restart) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        cnt_q <= at_term ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_launch_ctl.sv
module conv_launch_ctl
  import conv_sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic standby_i,
  input  logic oneshot_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o
);
  lnch_state_e state_q;
  logic        start_q;
  logic        fire;

  assign fire = (state_q == LNCH_IDLE) && (expire_i || (standby_i && oneshot_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LNCH_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= fire;
      case (state_q)
        LNCH_IDLE: if (fire)   state_q <= LNCH_BUSY;
        LNCH_BUSY: if (done_i) state_q <= LNCH_IDLE;
        default:               state_q <= LNCH_IDLE;
      endcase
    end
  end

  assign start_o = start_q;
  assign busy_o  = (state_q == LNCH_BUSY);
endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int unsigned RATE_W = conv_sched_pkg::RATE_BITS,
  parameter int unsigned CODE_W = conv_sched_pkg::CODE_BITS,
  localparam int unsigned CNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              standby_i,
  input  logic              oneshot_wr_i,
  input  logic              conv_done_i,
  output logic              start_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  term;
  logic              expire;

  conv_rate_decode #(.RATE_W(RATE_W), .CODE_W(CODE_W)) u_dec (
    .rate_i (rate_i),
    .code_o (code),
    .term_o (term)
  );

  conv_period_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .run_i    (!standby_i),
    .code_i   (code),
    .term_i   (term),
    .expire_o (expire)
  );

  conv_launch_ctl u_lnch (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_i  (expire),
    .standby_i (standby_i),
    .oneshot_i (oneshot_wr_i),
    .done_i    (conv_done_i),
    .start_o   (start_o),
    .busy_o    (busy_o)
  );
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic standby_i,
  input logic oneshot_wr_i,
  input logic conv_done_i,
  input logic start_o,
  input logic busy_o
);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  assert_busy_with_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);

  assert_busy_falls_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(conv_done_i));

  assert_no_start_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(busy_o));

  assert_standby_needs_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && $past(standby_i)) |-> $past(oneshot_wr_i));
endmodule

bind conv_sched conv_sched_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .standby_i    (standby_i),
  .oneshot_wr_i (oneshot_wr_i),
  .conv_done_i  (conv_done_i),
  .start_o      (start_o),
  .busy_o       (busy_o)
);

// File: tb/conv_sched_test.sv
`timescale 1ns/1ps
module conv_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] rate_i = 8'h00;
  logic       standby_i = 1'b0;
  logic       oneshot_wr_i = 1'b0;
  logic       conv_done_i = 1'b0;
  logic       start_o, busy_o;
  int         n_vec = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  conv_sched uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rate_i(rate_i),
    .standby_i(standby_i), .oneshot_wr_i(oneshot_wr_i),
    .conv_done_i(conv_done_i), .start_o(start_o), .busy_o(busy_o)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // one tick, then close any started conversion
  task automatic tick_once(input logic exp_start, input string req);
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
    check(start_o, exp_start, req);
    if (start_o) begin
      check(busy_o, 1'b1, "R4 busy with start");
      conv_done_i = 1'b1;
      step();
      conv_done_i = 1'b0;
      check(busy_o, 1'b0, "R4 busy cleared by done");
      check(start_o, 1'b0, "R2 single-cycle start");
    end
    step();
  endtask

  task automatic sweep(input logic [7:0] rate, input int period, input string req);
    rate_i = rate;
    step(); step();
    for (int k = 1; k <= 2 * period; k++)
      tick_once((k % period) == 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all R actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(start_o, 1'b0, "R1 start in reset");
    check(busy_o, 1'b0, "R1 busy in reset");
    rst_n = 1'b1;
    step();
    check(start_o, 1'b0, "R1 start after reset");
    check(busy_o, 1'b0, "R1 busy after reset");

    // R2: every legal code over two periods
    for (int c = 0; c < 8; c++)
      sweep(8'(c), 1 << (7 - c), "R2 period sweep");
    // R3: reserved values act as code 0
    sweep(8'h08, 128, "R3 reserved 08h");
    sweep(8'hFF, 128, "R3 reserved FFh");

    // R6: rate change mid-period restarts the count
    rate_i = 8'h00; step();
    for (int k = 0; k < 50; k++) tick_once(1'b0, "R6 before change");
    rate_i = 8'h05; step();
    for (int k = 1; k <= 4; k++) tick_once(k == 4, "R6 new period after change");

    // R5: period ends while busy -> dropped
    rate_i = 8'h07; step();
    tick_i = 1'b1; step(); tick_i = 1'b0;
    check(start_o, 1'b1, "R5 first start");
    step();
    tick_i = 1'b1; step(); tick_i = 1'b0;
    check(start_o, 1'b0, "R5 dropped while busy");
    check(busy_o, 1'b1, "R5 still busy");
    conv_done_i = 1'b1; step(); conv_done_i = 1'b0;
    check(busy_o, 1'b0, "R4 busy cleared");
    tick_once(1'b1, "R5 start resumes");

    // R7: standby blocks periodic starts
    standby_i = 1'b1; step();
    for (int k = 0; k < 10; k++) tick_once(1'b0, "R7 no start in standby");
    check(busy_o, 1'b0, "R7 idle in standby");

    // R8: one-shot in standby
    oneshot_wr_i = 1'b1; step(); oneshot_wr_i = 1'b0;
    check(start_o, 1'b1, "R8 one-shot start");
    check(busy_o, 1'b1, "R8 one-shot busy");
    // R9: one-shot while busy ignored
    oneshot_wr_i = 1'b1; step(); oneshot_wr_i = 1'b0;
    check(start_o, 1'b0, "R9 one-shot while busy");
    step();
    check(start_o, 1'b0, "R9 no late start");
    conv_done_i = 1'b1; step(); conv_done_i = 1'b0;
    check(busy_o, 1'b0, "R8 done clears busy");
    for (int k = 0; k < 3; k++) tick_once(1'b0, "R8 remains in standby");

    // R7: return to run restarts full period
    rate_i = 8'h05;
    standby_i = 1'b0; step();
    for (int k = 1; k <= 4; k++) tick_once(k == 4, "R7 first period after run");

    // R9: one-shot in run mode ignored
    rate_i = 8'h00; step();
    for (int k = 0; k < 3; k++) tick_once(1'b0, "R9 run ticks");
    oneshot_wr_i = 1'b1; step(); oneshot_wr_i = 1'b0;
    check(start_o, 1'b0, "R9 one-shot in run");
    step();
    check(busy_o, 1'b0, "R9 no busy from run one-shot");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule